// File: doc/BRIEF.md
# I2C Slave Engine with Acknowledge Control

This block is the slave half of an I2C port. It watches the open-drain SCL and SDA lines, finds START and STOP conditions, and compares the first byte after each START with a 7-bit address that software programs. It can also answer the general call address. Once addressed, it receives bytes or sends them, depending on the direction bit. After every byte it posts an event code, raises an interrupt and holds SCL low until software has handled the event.

Software uses a four-entry register file. Entry 0 holds the address setup. Entry 1 is control. Entry 2 is the data byte, and entry 3 is the event code. The assert-acknowledge bit in control can take the slave off the bus at any time without breaking its view of bus state. Master operation, arbitration and clock generation are not part of this block.

Top module: `i2c_slave_ack`

## Requirements
- R1: After reset, both pad pulls are inactive and irq is low. Reading status (entry 3) returns 0xF8, and reading control (entry 1) returns 0x00.
- R2: Entry 0 holds the own address in bits [7:1]. When control bit 0 (enable) and bit 1 (ack-enable) are set, and bits 2 and 3 (request bits) are clear, a first byte equal to {own, 0} is acknowledged (SDA pulled low in the 9th clock). Status then reads 0x60 and irq rises.
- R3: When entry 0 bit 0 is set, the byte 0x00 is acknowledged with status 0x70. When that bit is clear, 0x00 gets no acknowledge and irq stays low.
- R4: Any of the following leaves the slave unresponsive: an address that does not match, ack-enable clear, either request bit set, or enable clear. SDA is never pulled and irq stays low. Setting ack-enable again (with enable set and both request bits clear) restores address recognition.
- R5: After the 9th clock of every byte that produces a status, SCL is held low until software writes control. Any control write clears irq and hold, after which status reads 0xF8.
- R6: In receive mode, each data byte is acknowledged, stored in the data entry (entry 2) and reported with status 0x80.
- R7: If ack-enable is clear at the end of the 8th data bit, that byte is answered with a not-acknowledge and reported with status 0x88. The slave then ignores further bytes until the next START.
- R8: After {own, 1} is acknowledged, status reads 0xA8. The next control write sends the data entry out MSB first. SDA stays stable while SCL is high. A master acknowledge is reported with status 0xB8.
- R9: A master not-acknowledge is reported with status 0xC0. After that the slave releases SDA for all further clocks until a START.
- R10: While the slave is addressed, a STOP gives status 0xA0 and a repeated START gives status 0x10, both without holding SCL. After a repeated START, address matching starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 address setup, 1 control, 2 data, 3 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low when high |
| sda_pull | output | 1 | Pull SDA low when high |
| irq | output | 1 | Event pending flag |

## Verification
The bench builds the block with the default two-stage synchronizer and a bus master that it models itself, with wired-AND lines. With a 7-bit address space, every address can be swept against one own address with general call enabled. That covers the match and mismatch decisions completely. Receive and transmit bytes come from simple arithmetic sequences, so each byte's expected value and acknowledge are known in advance. The gating control values, the mid-transfer not-acknowledge, the master not-acknowledge and the repeated START are each exercised directly.

// File: rtl/i2c_slave_ack.sv
module i2c_slave_ack #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       irq
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TXW, S_TX, S_TACK} st_t;

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_r, sda_r, scl_q, sda_q;
  logic [6:0] own_addr;
  logic gc_en, en, ack_en, sta_req, sto_req, flag, hold;
  logic [7:0] dat, sh, stat;
  logic [3:0] cnt;
  logic ackd, is_read, is_gc;
  st_t st;

  assign scl_r = scl_s[SYNC_STAGES-1];
  assign sda_r = sda_s[SYNC_STAGES-1];

  logic start_c, stop_c, rise, fall, active, addressed, hit_own, hit_gc;
  assign start_c   = en & scl_r & scl_q & sda_q & ~sda_r;
  assign stop_c    = en & scl_r & scl_q & ~sda_q & sda_r;
  assign rise      = scl_r & ~scl_q;
  assign fall      = ~scl_r & scl_q;
  assign active    = en & ack_en & ~sta_req & ~sto_req;
  assign addressed = (st != S_IDLE) && (st != S_ADDR);
  assign hit_own   = (sh[7:1] == own_addr);
  assign hit_gc    = gc_en && (sh[7:1] == 7'd0) && !sh[0];

  assign sda_pull = (st == S_AACK) || (st == S_RACK && ackd) || (st == S_TX && !sh[7]);
  assign scl_pull = hold;
  assign irq      = flag;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {own_addr, gc_en};
      2'd1:    reg_rdata = {3'b000, flag, sto_req, sta_req, ack_en, en};
      2'd2:    reg_rdata = dat;
      default: reg_rdata = flag ? stat : 8'hF8;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
      own_addr <= '0; gc_en <= 1'b0;
      en <= 1'b0; ack_en <= 1'b0; sta_req <= 1'b0; sto_req <= 1'b0;
      flag <= 1'b0; hold <= 1'b0;
      dat <= '0; sh <= '0; stat <= 8'hF8; cnt <= '0;
      ackd <= 1'b0; is_read <= 1'b0; is_gc <= 1'b0;
      st <= S_IDLE;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_in};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_in};
      scl_q <= scl_r;
      sda_q <= sda_r;

      if (reg_wr) begin
        case (reg_addr)
          2'd0: {own_addr, gc_en} <= reg_wdata;
          2'd1: begin
            en <= reg_wdata[0]; ack_en <= reg_wdata[1];
            sta_req <= reg_wdata[2]; sto_req <= reg_wdata[3];
            flag <= 1'b0; hold <= 1'b0;
            if (st == S_TXW) begin
              sh <= dat; cnt <= '0; st <= S_TX;
            end
          end
          2'd2: dat <= reg_wdata;
          default: ;
        endcase
      end

      if (!en) begin
        st <= S_IDLE;
      end else if (start_c) begin
        if (addressed) begin
          stat <= 8'h10; flag <= 1'b1; hold <= 1'b0;
        end
        st <= S_ADDR; cnt <= '0;
      end else if (stop_c) begin
        if (addressed) begin
          stat <= 8'hA0; flag <= 1'b1; hold <= 1'b0;
        end
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (rise && cnt < 4'd8) begin
              sh <= {sh[6:0], sda_r};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (active && (hit_own || hit_gc)) begin
                  st <= S_AACK;
                  is_read <= sh[0];
                  is_gc <= !hit_own;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                dat <= sh;
                ackd <= ack_en;
                st <= S_RACK;
              end
            end
          end
          S_AACK: if (fall) begin
            stat <= is_gc ? 8'h70 : (is_read ? 8'hA8 : 8'h60);
            flag <= 1'b1; hold <= 1'b1;
            st <= is_read ? S_TXW : S_RX;
            cnt <= '0;
          end
          S_RACK: if (fall) begin
            stat <= ackd ? 8'h80 : 8'h88;
            flag <= 1'b1; hold <= 1'b1;
            st <= ackd ? S_RX : S_IDLE;
            cnt <= '0;
          end
          S_TX: if (fall) begin
            sh <= {sh[6:0], 1'b1};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_TACK;
          end
          S_TACK: begin
            if (rise) ackd <= !sda_r;
            else if (fall) begin
              stat <= ackd ? 8'hB8 : 8'hC0;
              flag <= 1'b1; hold <= 1'b1;
              st <= ackd ? S_TXW : S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_hold_implies_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> irq);
  p_stop_releases_sda_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull);
  p_tx_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && $past(st == S_TX) && scl_r && $past(scl_r)) |-> $stable(sda_pull));
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pull);
  p_status_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat inside {8'h10, 8'h60, 8'h70, 8'h80, 8'h88, 8'hA0, 8'hA8, 8'hB8, 8'hC0}));
endmodule

// File: tb/tb_i2c_slave_ack.sv
module tb_i2c_slave_ack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] ra = 2'd0;
  logic rw = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_pull, sda_pull, irq;
  logic scl_l, sda_l;
  assign scl_l = m_scl & ~scl_pull;
  assign sda_l = m_sda & ~sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h3A;

  i2c_slave_ack dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_wr(rw), .reg_wdata(wd), .reg_rdata(rd),
    .scl_in(scl_l), .sda_in(sda_l), .scl_pull(scl_pull), .sda_pull(sda_pull), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); ra = a; wd = d; rw = 1'b1;
    @(negedge clk); rw = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #1 d = rd;
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_l);
    wait_q();
  endtask

  task automatic m_start(); m_sda = 1'b1; wait_q(); scl_high(); m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q(); endtask
  task automatic m_stop(); m_sda = 1'b0; wait_q(); scl_high(); m_sda = 1'b1; wait_q(); endtask

  task automatic bit_out(input logic b); m_sda = b; wait_q(); scl_high(); m_scl = 1'b0; wait_q(); endtask

  task automatic bit_in(output logic b, output logic st);
    m_sda = 1'b1; wait_q(); scl_high();
    b = sda_l; wait_q(); st = (sda_l == b);
    m_scl = 1'b0; wait_q();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack, s);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic stab, input logic mnack);
    logic x, s;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x, s);
      b[i] = x;
      stab = stab & s;
    end
    bit_out(mnack);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] s, d, got;
    logic ack, stab;
    logic [7:0] cv [4];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk(!sda_pull && !scl_pull && !irq, "R1 pins", {sda_pull, scl_pull, irq}, 0);
    br(2'd3, s); chk(s == 8'hF8, "R1 status", s, 8'hF8);
    br(2'd1, s); chk(s == 8'h00, "R1 control", s, 0);

    bw(2'd0, {OWN, 1'b1});
    bw(2'd1, 8'h03);

    for (int a = 0; a < 128; a++) begin
      logic exp;
      exp = (a == int'(OWN)) || (a == 0);
      m_start();
      write_byte({7'(a), 1'b0}, ack);
      chk(ack == !exp, exp ? (a == 0 ? "R3 gc ack" : "R2 own ack") : "R4 mismatch nack", ack, !exp);
      if (exp) begin
        br(2'd3, s);
        chk(s == (a == 0 ? 8'h70 : 8'h60), "R2 R3 status", s, (a == 0 ? 8'h70 : 8'h60));
        chk(irq && scl_l == 1'b0 && scl_pull, "R5 stretch", {irq, scl_pull}, 3);
        bw(2'd1, 8'h03);
        br(2'd3, s);
        chk(s == 8'hF8 && !irq && !scl_pull, "R5 clear", s, 8'hF8);
        m_stop();
        br(2'd3, s); chk(s == 8'hA0 && !scl_pull, "R10 stop", s, 8'hA0);
        bw(2'd1, 8'h03);
      end else begin
        chk(!irq, "R4 no irq", irq, 0);
        m_stop();
        chk(!irq, "R4 no irq after stop", irq, 0);
      end
    end

    bw(2'd0, {OWN, 1'b0});
    m_start(); write_byte(8'h00, ack);
    chk(ack == 1'b1 && !irq, "R3 gc disabled", {ack, irq}, 2);
    m_stop();

    cv[0] = 8'h01; cv[1] = 8'h02; cv[2] = 8'h07; cv[3] = 8'h0B;
    for (int k = 0; k < 4; k++) begin
      bw(2'd1, cv[k]);
      m_start(); write_byte({OWN, 1'b0}, ack);
      chk(ack == 1'b1 && !irq, "R4 gated", {ack, irq}, 2);
      m_stop();
    end
    bw(2'd1, 8'h03);
    m_start(); write_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0 && irq, "R4 resume", {ack, irq}, 1);
    bw(2'd1, 8'h03);

    for (int k = 0; k < 8; k++) begin
      d = 8'((k * 53 + 17) & 255);
      write_byte(d, ack);
      chk(ack == 1'b0, "R6 data ack", ack, 0);
      br(2'd3, s); chk(s == 8'h80, "R6 status", s, 8'h80);
      br(2'd2, s); chk(s == d, "R6 data", s, d);
      chk(scl_pull, "R5 data stretch", scl_pull, 1);
      if (k < 7) bw(2'd1, 8'h03);
    end
    bw(2'd1, 8'h01);
    write_byte(8'h5C, ack);
    chk(ack == 1'b1, "R7 nack", ack, 1);
    br(2'd3, s); chk(s == 8'h88, "R7 status", s, 8'h88);
    br(2'd2, s); chk(s == 8'h5C, "R7 data", s, 8'h5C);
    bw(2'd1, 8'h01);
    write_byte(8'h33, ack);
    chk(ack == 1'b1 && !irq, "R7 ignored", {ack, irq}, 2);
    m_stop();
    chk(!irq, "R7 no stop event", irq, 0);
    bw(2'd1, 8'h03);

    m_start(); write_byte({OWN, 1'b1}, ack);
    chk(ack == 1'b0, "R8 read addr ack", ack, 0);
    br(2'd3, s); chk(s == 8'hA8 && scl_pull, "R8 status", s, 8'hA8);
    for (int k = 0; k < 4; k++) begin
      d = 8'((k * 91 + 6) & 255);
      bw(2'd2, d); bw(2'd1, 8'h03);
      read_byte(got, stab, k == 3);
      chk(got == d, "R8 tx byte", got, d);
      chk(stab, "R8 sda stable", stab, 1);
      br(2'd3, s);
      chk(s == (k == 3 ? 8'hC0 : 8'hB8), k == 3 ? "R9 master nack" : "R8 master ack", s, (k == 3 ? 8'hC0 : 8'hB8));
    end
    bw(2'd1, 8'h03);
    read_byte(got, stab, 1'b1);
    chk(got == 8'hFF && !irq, "R9 released", got, 8'hFF);
    m_stop();
    chk(!irq, "R9 idle stop", irq, 0);

    m_start(); write_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R10 addr", ack, 0);
    bw(2'd1, 8'h03);
    m_start();
    br(2'd3, s); chk(s == 8'h10 && irq && !scl_pull, "R10 restart", s, 8'h10);
    bw(2'd1, 8'h03);
    write_byte({OWN, 1'b1}, ack);
    br(2'd3, s); chk(ack == 1'b0 && s == 8'hA8, "R10 readdress", s, 8'hA8);
    bw(2'd2, 8'hFF); bw(2'd1, 8'h03);
    m_stop();
    br(2'd3, s); chk(s == 8'hA0 && !sda_pull, "R10 stop in tx", s, 8'hA0);
    bw(2'd1, 8'h03);
    br(2'd3, s); chk(s == 8'hF8, "R5 final clear", s, 8'hF8);

    finish_run();
  end
endmodule